// File: doc/BRIEF.md
# Single/Double Float Load-Store Converter

This block sits between a register file that holds 64-bit IEEE-754 double-precision values and a memory port that is 32 bits wide. On the load path it widens a single-precision word read from memory into the double format the registers use. On the store path it narrows a register's double value into a single-precision word for memory.

Neither path raises an exception or changes a status flag. A stored operand is assumed to already be a value that fits the single format. It is not rounded and its range is not checked. Its fraction is truncated to 23 bits, and a value below the single normal range is denormalized by a right shift.

A direction select decides which of the two output registers captures its conversion on each clock. The other register holds its value. Results appear one cycle after the inputs are presented.

Top module: `fp_ls_convert`

## Requirements
- R1: A synchronous active-high reset clears both the load result and the store result to all zeros at the next rising clock edge.
- R2: Load of a normal single (exponent field 1..254) yields the same sign, a double exponent equal to the single exponent plus 896, and the 23 single fraction bits as double fraction bits 51..29.
- R3: Load of a signed zero (single exponent and fraction both zero) yields a double zero carrying the same sign bit (bit 63 equals input bit 31).
- R4: Load of a single denormal (exponent zero, fraction f nonzero, leading one at fraction bit p) yields a normalized double with exponent 874+p and the fraction bits below that leading one left-aligned at double fraction bit 51.
- R5: Load of a single with exponent field 255 yields double exponent 2047 with the 23 fraction bits copied to double bits 51..29. Infinities stay infinities and the quiet bit (single bit 22, double bit 51) is kept.
- R6: Store of a double with biased exponent E of 897 or more (which includes 2047) yields a word with {sign, E bit 10, E bits 6..0, double fraction bits 51..29}. Lower fraction bits are discarded.
- R7: Store of a double with 874 <= E <= 896 yields a single denormal: exponent field zero, and fraction equal to the 24-bit significand {1, fraction bits 51..29} shifted right by 897-E and truncated.
- R8: Store of a double with E below 874 (including zero and double denormals) yields a zero word that keeps the sign bit.
- R9: Select low (load) updates only the load result and select high (store) updates only the store result. The other result holds its previous value, and the updated one is valid one cycle after the inputs.
- R10: Every load result has its low 29 double fraction bits (bits 28..0) equal to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_store | input | 1 | 0: convert the memory word (load), 1: convert the register word (store) |
| mem_word_i | input | 32 | Single-precision word from memory |
| reg_word_i | input | 64 | Double-precision register operand |
| ld_word_o | output | 64 | Registered double result of the load path |
| st_word_o | output | 32 | Registered single result of the store path |

## Verification
Load conversion is exercised with normal values, both signed zeros, single denormals with the leading one at every fraction position, infinities, and quiet and signaling NaNs. This separates the re-bias path, the normalize path and the pass-through path of the exponent decode, and a sweep over all 23 positions exposes an off-by-one in the leading-zero count. Store conversion is exercised at the exponent boundaries 897, 896, 874 and 873. It is also given fractions whose discarded low bits are nonzero, which distinguishes truncation from rounding and the denormal shift from the normal repack. Alternating directions with changing idle inputs shows that the unselected result register holds its value.

// File: rtl/fpconv_pkg.sv
package fpconv_pkg;

  typedef enum logic {
    DIR_LOAD  = 1'b0,
    DIR_STORE = 1'b1
  } conv_dir_e;

  // Exponent bias for an IEEE-754 format with the given exponent width
  function automatic int fmt_bias(input int exp_w);
    return (1 << (exp_w - 1)) - 1;
  endfunction

endpackage

// File: rtl/lead_zero_cnt.sv
module lead_zero_cnt #(
  parameter int W  = 23,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);

  // Ascending scan: the highest set bit is the last one to write the count
  always_comb begin
    cnt_o = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) cnt_o = CW'(W - 1 - i);
    end
  end

endmodule

// File: rtl/sp_widen.sv
module sp_widen
  import fpconv_pkg::*;
#(
  parameter int SE = 8,
  parameter int SF = 23,
  parameter int DE = 11,
  parameter int DF = 52
) (
  input  logic [SE+SF:0] sp_i,
  output logic [DE+DF:0] dp_o
);

  localparam int SW        = 1 + SE + SF;
  localparam int PAD       = DF - SF;
  localparam int LZW       = $clog2(SF + 1);
  localparam int BIAS_DIFF = fmt_bias(DE) - fmt_bias(SE);
  localparam logic [LZW:0] SH_ONE = {{LZW{1'b0}}, 1'b1};

  logic          sgn;
  logic [SE-1:0] sexp;
  logic [SF-1:0] sfrac;
  logic [LZW-1:0] lz;
  logic [LZW:0]  nrm_sh;
  logic [SF-1:0] nrm_frac;
  logic [DE-1:0] dexp;
  logic [SF-1:0] dfrac;

  assign sgn   = sp_i[SW-1];
  assign sexp  = sp_i[SW-2 -: SE];
  assign sfrac = sp_i[SF-1:0];

  lead_zero_cnt #(.W(SF), .CW(LZW)) u_lzc (
    .vec_i (sfrac),
    .cnt_o (lz)
  );

  // Shift past the leading one so it becomes the hidden bit
  assign nrm_sh   = {1'b0, lz} + SH_ONE;
  assign nrm_frac = sfrac << nrm_sh;

  always_comb begin
    if (sexp == {SE{1'b1}}) begin
      dexp  = {DE{1'b1}};
      dfrac = sfrac;
    end else if (sexp == '0 && sfrac == '0) begin
      dexp  = '0;
      dfrac = '0;
    end else if (sexp == '0) begin
      dexp  = DE'(BIAS_DIFF) - DE'(lz);
      dfrac = nrm_frac;
    end else begin
      dexp  = DE'(sexp) + DE'(BIAS_DIFF);
      dfrac = sfrac;
    end
  end

  assign dp_o = {sgn, dexp, dfrac, {PAD{1'b0}}};

endmodule

// File: rtl/dp_narrow.sv
module dp_narrow
  import fpconv_pkg::*;
#(
  parameter int SE = 8,
  parameter int SF = 23,
  parameter int DE = 11,
  parameter int DF = 52
) (
  input  logic [DE+DF:0] dp_i,
  output logic [SE+SF:0] sp_o
);

  localparam int DW       = 1 + DE + DF;
  localparam int MIN_NORM = fmt_bias(DE) - fmt_bias(SE) + 1;
  localparam int DEN_LOW  = MIN_NORM - SF;

  logic          sgn;
  logic [DE-1:0] dexp;
  logic [SF-1:0] top_frac;
  logic [SF:0]   sig;
  logic [DE-1:0] den_sh;
  logic [SF:0]   den;

  assign sgn      = dp_i[DW-1];
  assign dexp     = dp_i[DW-2 -: DE];
  assign top_frac = dp_i[DF-1 -: SF];
  assign sig      = {1'b1, top_frac};
  assign den_sh   = DE'(MIN_NORM) - dexp;
  assign den      = sig >> den_sh;

  always_comb begin
    if (dexp >= DE'(MIN_NORM)) begin
      sp_o = {sgn, dexp[DE-1], dexp[SE-2:0], top_frac};
    end else if (dexp >= DE'(DEN_LOW)) begin
      sp_o = {sgn, {SE{1'b0}}, den[SF-1:0]};
    end else begin
      sp_o = {sgn, {(SE + SF){1'b0}}};
    end
  end

endmodule

// File: rtl/fp_ls_convert.sv
module fp_ls_convert
  import fpconv_pkg::*;
#(
  parameter int SP_EXP_W  = 8,
  parameter int SP_FRAC_W = 23,
  parameter int DP_EXP_W  = 11,
  parameter int DP_FRAC_W = 52
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             sel_store,
  input  logic [SP_EXP_W+SP_FRAC_W:0]      mem_word_i,
  input  logic [DP_EXP_W+DP_FRAC_W:0]      reg_word_i,
  output logic [DP_EXP_W+DP_FRAC_W:0]      ld_word_o,
  output logic [SP_EXP_W+SP_FRAC_W:0]      st_word_o
);

  localparam int SW      = 1 + SP_EXP_W + SP_FRAC_W;
  localparam int DW      = 1 + DP_EXP_W + DP_FRAC_W;
  localparam int PAD     = DP_FRAC_W - SP_FRAC_W;
  localparam int DEN_LOW = fmt_bias(DP_EXP_W) - fmt_bias(SP_EXP_W) + 1 - SP_FRAC_W;

  conv_dir_e     dir;
  logic [DW-1:0] wide;
  logic [SW-1:0] narrow;

  assign dir = sel_store ? DIR_STORE : DIR_LOAD;

  sp_widen #(
    .SE(SP_EXP_W), .SF(SP_FRAC_W), .DE(DP_EXP_W), .DF(DP_FRAC_W)
  ) u_widen (
    .sp_i (mem_word_i),
    .dp_o (wide)
  );

  dp_narrow #(
    .SE(SP_EXP_W), .SF(SP_FRAC_W), .DE(DP_EXP_W), .DF(DP_FRAC_W)
  ) u_narrow (
    .dp_i (reg_word_i),
    .sp_o (narrow)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_word_o <= '0;
      st_word_o <= '0;
    end else if (dir == DIR_STORE) begin
      st_word_o <= narrow;
    end else begin
      ld_word_o <= wide;
    end
  end

  // R9
  ld_hold_chk: assert property (@(posedge clk) disable iff (rst)
    sel_store |=> $stable(ld_word_o));

  // R9
  st_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !sel_store |=> $stable(st_word_o));

  // R3
  ld_sign_chk: assert property (@(posedge clk) disable iff (rst)
    !sel_store |=> ld_word_o[DW-1] == $past(mem_word_i[SW-1]));

  // R5
  ld_special_chk: assert property (@(posedge clk) disable iff (rst)
    (!sel_store && mem_word_i[SW-2 -: SP_EXP_W] == {SP_EXP_W{1'b1}})
      |=> ld_word_o[DW-2 -: DP_EXP_W] == {DP_EXP_W{1'b1}});

  // R8
  st_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_store && reg_word_i[DW-2 -: DP_EXP_W] < DP_EXP_W'(DEN_LOW))
      |=> (st_word_o[SW-2:0] == '0 && st_word_o[SW-1] == $past(reg_word_i[DW-1])));

  // R10
  ld_lowfrac_chk: assert property (@(posedge clk) disable iff (rst)
    ld_word_o[PAD-1:0] == '0);

endmodule

// File: tb/fp_ls_convert_tb.sv
`timescale 1ns/1ps
module fp_ls_convert_tb;

  typedef struct packed {
    logic        st;
    logic [63:0] din;
    logic [63:0] want;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 64'h3F800000, 64'h3FF0000000000000},             // R2 1.0
    '{1'b0, 64'hC0200000, 64'hC004000000000000},             // R2 -2.5
    '{1'b0, 64'h7F7FFFFF, 64'h47EFFFFFE0000000},             // R2 max normal
    '{1'b0, 64'h00800000, 64'h3810000000000000},             // R2 min normal
    '{1'b0, 64'h00000000, 64'h0000000000000000},             // R3 +0
    '{1'b0, 64'h80000000, 64'h8000000000000000},             // R3 -0
    '{1'b0, 64'h00000001, 64'h36A0000000000000},             // R4 smallest denormal
    '{1'b0, 64'h00400000, 64'h3800000000000000},             // R4 top denormal bit
    '{1'b0, 64'h80600000, 64'hB808000000000000},             // R4 negative denormal
    '{1'b0, 64'h7F800000, 64'h7FF0000000000000},             // R5 +inf
    '{1'b0, 64'hFF800000, 64'hFFF0000000000000},             // R5 -inf
    '{1'b0, 64'h7FC00000, 64'h7FF8000000000000},             // R5 quiet NaN
    '{1'b0, 64'h7F800001, 64'h7FF0000020000000},             // R5 signaling NaN
    '{1'b1, 64'h3FF0000000000000, 64'h3F800000},             // R6 1.0
    '{1'b1, 64'hC004000000000000, 64'hC0200000},             // R6 -2.5
    '{1'b1, 64'h47EFFFFFE0000000, 64'h7F7FFFFF},             // R6 max normal
    '{1'b1, 64'h3810000000000000, 64'h00800000},             // R6 E=897
    '{1'b1, 64'h3FF00000E0000000, 64'h3F800007},             // R6 kept low bits
    '{1'b1, 64'h3FF000001FFFFFFF, 64'h3F800000},             // R6 truncation
    '{1'b1, 64'h7FF8000000000000, 64'h7FC00000},             // R6 quiet NaN
    '{1'b1, 64'hFFF0000000000000, 64'hFF800000},             // R6 -inf
    '{1'b1, 64'h3800000000000000, 64'h00400000},             // R7 E=896
    '{1'b1, 64'hB808000000000000, 64'h80600000},             // R7 negative
    '{1'b1, 64'h36B8000000000000, 64'h00000003},             // R7 E=875
    '{1'b1, 64'h36AFFFFFFFFFFFFF, 64'h00000001},             // R7 E=874 truncated
    '{1'b1, 64'h3690000000000000, 64'h00000000},             // R8 E=873
    '{1'b1, 64'h8000000000000001, 64'h80000000}              // R8 negative tiny
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel_store = 1'b0;
  logic [31:0] mem_word_i = '0;
  logic [63:0] reg_word_i = '0;
  logic [63:0] ld_word_o;
  logic [31:0] st_word_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [63:0] exp_ld = '0;
  logic [31:0] exp_st = '0;

  always #2 clk = ~clk;

  fp_ls_convert u_dut (
    .clk        (clk),
    .rst        (rst),
    .sel_store  (sel_store),
    .mem_word_i (mem_word_i),
    .reg_word_i (reg_word_i),
    .ld_word_o  (ld_word_o),
    .st_word_o  (st_word_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] want);
    n_chk++;
    if (act !== want) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, want);
    end
  endtask

  task automatic apply(input logic st, input logic [63:0] din);
    @(negedge clk);
    sel_store = st;
    if (st) reg_word_i = din;
    else    mem_word_i = din[31:0];
    // idle input wanders so a leak into the held path would show
    if (st) mem_word_i = ~mem_word_i;
    else    reg_word_i = ~reg_word_i;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset load", ld_word_o, 64'h0);
    chk("R1 reset store", {32'h0, st_word_o}, 64'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].st, VECS[i].din);
      if (VECS[i].st) begin
        exp_st = VECS[i].want[31:0];
        chk("R6/R7/R8 store vector", {32'h0, st_word_o}, {32'h0, exp_st});
        chk("R9 load held", ld_word_o, exp_ld);
      end else begin
        exp_ld = VECS[i].want;
        chk("R2/R3/R4/R5 load vector", ld_word_o, exp_ld);
        chk("R9 store held", {32'h0, st_word_o}, {32'h0, exp_st});
        chk("R10 low fraction", {35'h0, ld_word_o[28:0]}, 64'h0);
      end
    end

    // R4 sweep: single value 2^(k-149) has double exponent 874+k
    for (int k = 0; k < 23; k++) begin
      apply(1'b0, 64'(32'h1 << k));
      exp_ld = {1'b0, 11'(874 + k), 52'h0};
      chk("R4 denormal sweep", ld_word_o, exp_ld);
    end

    // R7 sweep: double 2^(k-149) stores as denormal fraction 1<<k
    for (int k = 0; k < 23; k++) begin
      apply(1'b1, {1'b0, 11'(874 + k), 52'h0});
      exp_st = 32'h1 << k;
      chk("R7 denormal sweep", {32'h0, st_word_o}, {32'h0, exp_st});
    end

    // R1 reset in mid-run clears both results
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid-run load", ld_word_o, 64'h0);
    chk("R1 mid-run store", {32'h0, st_word_o}, 64'h0);
    rst = 1'b0;

    // R9 one-cycle latency: a load right after reset
    apply(1'b0, 64'h3F800000);
    chk("R9 latency", ld_word_o, 64'h3FF0000000000000);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule